// File: doc/BRIEF.md
# Serial Flash Pin Role Controller

This block sits at the pin edge of a serial NOR flash slave. It decides, cycle by cycle, whether the two multi-purpose pins act as control inputs or as data lanes. One pin is a pause input that can also act as data lane 3. The other is a write-protect input that can also act as data lane 2. The choice depends on the active protocol, on the double-transfer-rate flag, on whether the current command moves data on four lanes, and on two hold-enable configuration bits.

All logic runs on a fast system clock `clk`, which oversamples the serial clock `sck`. A pause starts and ends only on a sampled falling edge of `sck`. While the transfer is paused, the block suppresses the shift strobe, freezes the small receive shifter and its bit counter, and drops every lane's output enable. The write-protect input gates program and erase requests that target the protected area; which addresses count as protected is decided elsewhere and arrives as `prot_hit`. The command engine consumes `shift_en`, `rx_data` and `rx_cnt`.

Top module: `sfpr_pin_ctl`

## Requirements
- R1: While reset is asserted and after its release, `hold_pause`, `shift_en`, `rx_cnt` and `rx_data` read zero until stimulus arrives.
- R2: A pause begins only on a sampled falling edge of `sck`. The pause needs `cs_n` low, `hold_pin` low and the hold function available. Taking `hold_pin` low while `sck` is high has no effect until the next falling edge, and `hold_pause` rises one `clk` after that edge is sampled.
- R3: A pause ends only on a sampled falling edge of `sck` with `hold_pin` high. Raising `hold_pin` while `sck` is low leaves `hold_pause` at 1.
- R4: While `hold_pause` is 1, rising edges of `sck` produce no `shift_en`, `si` is not captured, and all four `dq_oe` bits are 0.
- R5: Bits shifted before a pause are kept. After the pause, shifting continues at the same `rx_cnt` position.
- R6: `hold_pin` is ignored while `cs_n` is high. Raising `cs_n` clears `hold_pause`, `shift_en`, `rx_cnt` and `rx_data` one `clk` later.
- R7: The hold function is unavailable unless both `nv_hold_en` and `ev_hold_en` are 1.
- R8: With `proto` = 2'b10 (quad; 2'b00 is extended and 2'b01 is dual), both pins take the data role (`dq2_is_data` = `dq3_is_data` = 1). In this mode there is no pause and no write protect.
- R9: While `dtr_seen` is 1, the hold function is unavailable. A pause in progress ends one `clk` after `dtr_seen` rises.
- R10: While `quad_xfer` is 1 in extended or dual protocol, both pins take the data role, with no pause and no write protect.
- R11: In extended or dual protocol without `quad_xfer`, `wp_assert` equals the inverse of `w_pin`. `modify_ok` is `modify_req` unless both `wp_assert` and `prot_hit` are 1.
- R12: `dq_oe[i]` follows `oe_req[i]` only while `cs_n` is low and there is no pause. Lanes 2 and 3 additionally need their pin in the data role, and lanes 0 and 1 have no role condition.
- R13: Each sampled rising edge of `sck` while selected and not paused gives one `clk`-wide `shift_en` pulse. On that pulse, `si` shifts into `rx_data` LSB first-in (MSB-first order), and `rx_cnt` steps by one, wrapping from DATA_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level |
| si | input | 1 | Serial input on lane 0 |
| w_pin | input | 1 | Write-protect pin level (lane 2 when data) |
| hold_pin | input | 1 | Pause pin level (lane 3 when data) |
| proto | input | 2 | 00 extended, 01 dual, 10 quad |
| dtr_seen | input | 1 | Double-transfer-rate operation recognised |
| quad_xfer | input | 1 | Current command uses four data lanes |
| nv_hold_en | input | 1 | Nonvolatile hold-enable bit (0 disables) |
| ev_hold_en | input | 1 | Volatile hold-enable bit (0 disables) |
| oe_req | input | 4 | Lane drive requests from the command engine |
| modify_req | input | 1 | Program or erase request |
| prot_hit | input | 1 | Request targets the protected area |
| hold_pause | output | 1 | Transfer paused |
| dq3_is_data | output | 1 | Pause pin is in the data role |
| dq2_is_data | output | 1 | Write-protect pin is in the data role |
| wp_assert | output | 1 | Write protect active |
| modify_ok | output | 1 | Modify request allowed |
| dq_oe | output | 4 | Gated lane output enables |
| shift_en | output | 1 | Shift strobe for the command engine |
| rx_cnt | output | CNT_W | Bit position in the current word |
| rx_data | output | DATA_W | Bits received so far |

## Verification
The role outputs, `wp_assert`, `modify_ok` and `dq_oe` are combinational, so they are checked one time step after their inputs change, with no clock edge in between. `hold_pause`, `shift_en`, `rx_cnt` and `rx_data` take one `clk` edge after the `sck`, `cs_n` or `dtr_seen` change that causes them. The bench drives every input just after a falling `clk` edge and reads these outputs at the next falling edge, so exactly one register stage lies between stimulus and sample. The deferral cases hold a level over two extra `clk` cycles before the `sck` edge, to show that nothing moves early.

// File: rtl/sfpr_pkg.sv
package sfpr_pkg;
  typedef enum logic [1:0] {
    PROTO_EXT  = 2'b00,
    PROTO_DUAL = 2'b01,
    PROTO_QUAD = 2'b10
  } proto_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/sfpr_role_dec.sv
module sfpr_role_dec
  import sfpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [1:0] proto,
  input  logic       dtr_seen,
  input  logic       quad_xfer,
  input  logic       nv_hold_en,
  input  logic       ev_hold_en,
  input  logic       w_pin,
  input  logic       modify_req,
  input  logic       prot_hit,
  output logic       dq2_data,
  output logic       dq3_data,
  output logic       hold_allow,
  output logic       wp_assert,
  output logic       modify_ok
);
  logic quad_proto;
  logic four_lane;

  always_comb begin
    quad_proto = (proto == PROTO_QUAD);
    four_lane  = quad_proto | quad_xfer;
    dq2_data   = four_lane;
    dq3_data   = four_lane;
    hold_allow = ~cs_n & ~four_lane & ~dtr_seen & nv_hold_en & ev_hold_en;
    wp_assert  = ~four_lane & ~w_pin;
    modify_ok  = modify_req & ~(wp_assert & prot_hit);
  end

  AST_QUAD_BOTH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (proto == PROTO_QUAD) |-> (dq2_data && dq3_data && !hold_allow && !wp_assert)); // R8
  AST_DTR_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dtr_seen |-> !hold_allow); // R9
  AST_CFG_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_hold_en || !ev_hold_en) |-> !hold_allow); // R7
  AST_WP_BLOCKS_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_assert && prot_hit) |-> !modify_ok); // R11
endmodule

// File: rtl/sfpr_hold_ctl.sv
module sfpr_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_pin,
  input  logic hold_allow,
  output logic sck_rise,
  output logic paused
);
  logic sck_q;
  logic sck_fall;
  logic paused_d;

  always_comb begin
    sck_rise = ~sck_q & sck;
    sck_fall = sck_q & ~sck;
    paused_d = paused;
    if (cs_n || !hold_allow) begin
      paused_d = 1'b0;
    end else if (sck_fall) begin
      paused_d = ~hold_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q  <= sck;
      paused <= paused_d;
    end
  end

  AST_PAUSE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> ($past(sck_q) && !$past(sck))); // R2
  AST_PAUSE_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> ($past(cs_n) || !$past(hold_allow) || ($past(sck_q) && !$past(sck)))); // R3
  AST_DESELECT_ENDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !paused); // R6
  AST_NO_PAUSE_UNAVAILABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hold_allow) |-> !paused); // R7
endmodule

// File: rtl/sfpr_shift.sv
module sfpr_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              paused,
  input  logic              si,
  output logic              shift_en,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              shift_now;
  logic [CNT_W-1:0]  cnt_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    shift_now = sck_rise & ~cs_n & ~paused;
    cnt_d     = rx_cnt;
    data_d    = rx_data;
    if (cs_n) begin
      cnt_d  = '0;
      data_d = '0;
    end else if (shift_now) begin
      cnt_d  = (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
      data_d = {rx_data[DATA_W-2:0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_en <= 1'b0;
      rx_cnt   <= '0;
      rx_data  <= '0;
    end else begin
      shift_en <= shift_now;
      rx_cnt   <= cnt_d;
      rx_data  <= data_d;
    end
  end

  AST_FROZEN_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(paused) && !$past(cs_n)) |-> ($stable(rx_data) && $stable(rx_cnt) && !shift_en)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (rx_cnt == (($past(rx_cnt) == LAST) ? '0 : $past(rx_cnt) + 1'b1))); // R13
  AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (rx_cnt == '0 && rx_data == '0 && !shift_en)); // R6
endmodule

// File: rtl/sfpr_pin_ctl.sv
module sfpr_pin_ctl
  import sfpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              w_pin,
  input  logic              hold_pin,
  input  logic [1:0]        proto,
  input  logic              dtr_seen,
  input  logic              quad_xfer,
  input  logic              nv_hold_en,
  input  logic              ev_hold_en,
  input  logic [3:0]        oe_req,
  input  logic              modify_req,
  input  logic              prot_hit,
  output logic              hold_pause,
  output logic              dq3_is_data,
  output logic              dq2_is_data,
  output logic              wp_assert,
  output logic              modify_ok,
  output logic [3:0]        dq_oe,
  output logic              shift_en,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic [DATA_W-1:0] rx_data
);
  logic             rst_meta_n;
  logic             rst_sync_n;
  logic             hold_allow;
  logic             sck_rise;
  logic [LANES-1:0] lane_role;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sfpr_role_dec u_role (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n       (cs_n),
    .proto      (proto),
    .dtr_seen   (dtr_seen),
    .quad_xfer  (quad_xfer),
    .nv_hold_en (nv_hold_en),
    .ev_hold_en (ev_hold_en),
    .w_pin      (w_pin),
    .modify_req (modify_req),
    .prot_hit   (prot_hit),
    .dq2_data   (dq2_is_data),
    .dq3_data   (dq3_is_data),
    .hold_allow (hold_allow),
    .wp_assert  (wp_assert),
    .modify_ok  (modify_ok)
  );

  sfpr_hold_ctl u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .hold_pin   (hold_pin),
    .hold_allow (hold_allow),
    .sck_rise   (sck_rise),
    .paused     (hold_pause)
  );

  sfpr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .paused   (hold_pause),
    .si       (si),
    .shift_en (shift_en),
    .rx_cnt   (rx_cnt),
    .rx_data  (rx_data)
  );

  assign lane_role = {dq3_is_data, dq2_is_data, 2'b11};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_oe[g] = oe_req[g] & lane_role[g] & ~cs_n & ~hold_pause;
  end

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |-> (dq_oe == 4'b0000)); // R12
  AST_PAUSE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_pause |-> (dq_oe == 4'b0000)); // R4
  AST_XFER_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(quad_xfer) |-> !hold_pause); // R10
endmodule

// File: tb/sfpr_pin_ctl_tb_top.sv
module sfpr_pin_ctl_tb_top;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, sck, si, w_pin, hold_pin;
  logic [1:0]        proto;
  logic              dtr_seen, quad_xfer, nv_hold_en, ev_hold_en;
  logic [3:0]        oe_req;
  logic              modify_req, prot_hit;
  logic              hold_pause, dq3_is_data, dq2_is_data, wp_assert, modify_ok;
  logic [3:0]        dq_oe;
  logic              shift_en;
  logic [CNT_W-1:0]  rx_cnt;
  logic [DATA_W-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sfpr_pin_ctl #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .w_pin(w_pin),
    .hold_pin(hold_pin), .proto(proto), .dtr_seen(dtr_seen), .quad_xfer(quad_xfer),
    .nv_hold_en(nv_hold_en), .ev_hold_en(ev_hold_en), .oe_req(oe_req),
    .modify_req(modify_req), .prot_hit(prot_hit), .hold_pause(hold_pause),
    .dq3_is_data(dq3_is_data), .dq2_is_data(dq2_is_data), .wp_assert(wp_assert),
    .modify_ok(modify_ok), .dq_oe(dq_oe), .shift_en(shift_en), .rx_cnt(rx_cnt),
    .rx_data(rx_data)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_to(logic v);
    sck = v;
    step();
  endtask

  task automatic clock_bit(logic b);
    si = b;
    sck_to(1'b1);
    sck_to(1'b0);
  endtask

  task automatic defaults();
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; w_pin = 1'b1; hold_pin = 1'b1;
    proto = 2'b00; dtr_seen = 1'b0; quad_xfer = 1'b0;
    nv_hold_en = 1'b1; ev_hold_en = 1'b1; oe_req = 4'b0011;
    modify_req = 1'b0; prot_hit = 1'b0;
  endtask

  task automatic idle();
    defaults();
    step(2);
  endtask

  task automatic t_reset();
    check("R1", "hold_pause", hold_pause, 0);
    check("R1", "shift_en", shift_en, 0);
    check("R1", "rx_cnt", rx_cnt, 0);
    check("R1", "rx_data", rx_data, 0);
  endtask

  task automatic t_shift_and_pause();
    idle();
    cs_n = 1'b0;
    step();
    si = 1'b1;
    sck_to(1'b1);
    check("R13", "shift_en pulse", shift_en, 1);
    sck_to(1'b0);
    check("R13", "shift_en one clk", shift_en, 0);
    clock_bit(1'b0);
    clock_bit(1'b1);
    check("R13", "rx_cnt", rx_cnt, 3);
    check("R13", "rx_data", rx_data, 8'h05);
    si = 1'b0;
    sck_to(1'b1);
    hold_pin = 1'b0;
    step(2);
    check("R2", "deferred while sck high", hold_pause, 0);
    sck_to(1'b0);
    check("R2", "pause on fall", hold_pause, 1);
    #1 check("R4", "dq_oe in pause", dq_oe, 4'b0000);
    si = 1'b1;
    sck_to(1'b1);
    check("R4", "no shift in pause", shift_en, 0);
    sck_to(1'b0);
    hold_pin = 1'b1;
    step(2);
    check("R3", "release deferred", hold_pause, 1);
    sck_to(1'b1);
    check("R4", "rise ignored", shift_en, 0);
    sck_to(1'b0);
    check("R3", "release on fall", hold_pause, 0);
    check("R5", "rx_cnt kept", rx_cnt, 4);
    check("R5", "rx_data kept", rx_data, 8'h0A);
    clock_bit(1'b1);
    check("R5", "resume cnt", rx_cnt, 5);
    check("R5", "resume data", rx_data, 8'h15);
    #1 check("R12", "dq_oe active", dq_oe, 4'b0011);
    clock_bit(1'b0);
    clock_bit(1'b1);
    clock_bit(1'b1);
    check("R13", "cnt wrap", rx_cnt, 0);
    check("R13", "full word", rx_data, 8'hAB);
  endtask

  task automatic t_deselect();
    idle();
    cs_n = 1'b0;
    step();
    hold_pin = 1'b0;
    si = 1'b1;
    sck_to(1'b1);
    sck_to(1'b0);
    check("R2", "paused before deselect", hold_pause, 1);
    cs_n = 1'b1;
    #1 check("R12", "dq_oe deselected", dq_oe, 4'b0000);
    step();
    check("R6", "pause cleared", hold_pause, 0);
    check("R6", "cnt cleared", rx_cnt, 0);
    check("R6", "data cleared", rx_data, 0);
    sck_to(1'b1);
    sck_to(1'b0);
    check("R6", "hold ignored deselected", hold_pause, 0);
  endtask

  task automatic t_cfg_disable();
    for (int k = 0; k < 2; k++) begin
      idle();
      if (k == 0) nv_hold_en = 1'b0; else ev_hold_en = 1'b0;
      cs_n = 1'b0;
      hold_pin = 1'b0;
      step();
      sck_to(1'b1);
      check("R7", "shift still runs", shift_en, 1);
      sck_to(1'b0);
      check("R7", "no pause cfg off", hold_pause, 0);
    end
  endtask

  task automatic t_quad();
    idle();
    proto = 2'b10;
    cs_n = 1'b0;
    hold_pin = 1'b0;
    w_pin = 1'b0;
    oe_req = 4'hF;
    modify_req = 1'b1;
    prot_hit = 1'b1;
    #1;
    check("R8", "dq2 role", dq2_is_data, 1);
    check("R8", "dq3 role", dq3_is_data, 1);
    check("R8", "no wp", wp_assert, 0);
    check("R8", "modify ok", modify_ok, 1);
    check("R12", "four lanes", dq_oe, 4'hF);
    step();
    sck_to(1'b1);
    sck_to(1'b0);
    check("R8", "no pause quad", hold_pause, 0);
  endtask

  task automatic t_dtr();
    idle();
    cs_n = 1'b0;
    hold_pin = 1'b0;
    dtr_seen = 1'b1;
    step();
    sck_to(1'b1);
    sck_to(1'b0);
    check("R9", "no pause dtr", hold_pause, 0);
    dtr_seen = 1'b0;
    sck_to(1'b1);
    sck_to(1'b0);
    check("R9", "pause without dtr", hold_pause, 1);
    dtr_seen = 1'b1;
    step();
    check("R9", "dtr ends pause", hold_pause, 0);
  endtask

  task automatic t_quad_xfer();
    idle();
    cs_n = 1'b0;
    quad_xfer = 1'b1;
    hold_pin = 1'b0;
    w_pin = 1'b0;
    oe_req = 4'hF;
    #1;
    check("R10", "dq2 role", dq2_is_data, 1);
    check("R10", "dq3 role", dq3_is_data, 1);
    check("R10", "no wp", wp_assert, 0);
    check("R12", "four lanes xfer", dq_oe, 4'hF);
    step();
    sck_to(1'b1);
    sck_to(1'b0);
    check("R10", "no pause xfer", hold_pause, 0);
  endtask

  task automatic t_wp();
    for (int p = 0; p < 2; p++) begin
      idle();
      proto = p[1:0];
      cs_n = 1'b0;
      oe_req = 4'hF;
      w_pin = 1'b0;
      modify_req = 1'b1;
      prot_hit = 1'b1;
      #1;
      check("R11", "wp asserted", wp_assert, 1);
      check("R11", "blocked", modify_ok, 0);
      check("R12", "lanes 2,3 gated", dq_oe, 4'b0011);
      prot_hit = 1'b0;
      #1 check("R11", "unprotected ok", modify_ok, 1);
      prot_hit = 1'b1;
      w_pin = 1'b1;
      #1;
      check("R11", "wp released", wp_assert, 0);
      check("R11", "allowed", modify_ok, 1);
      modify_req = 1'b0;
      #1 check("R11", "no request", modify_ok, 0);
      step();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    defaults();
    rst_n = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_shift_and_pause();
    t_deselect();
    t_cfg_disable();
    t_quad();
    t_dtr();
    t_quad_xfer();
    t_wp();
    idle();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule